// File: doc/BRIEF.md
# Radial Lens Distortion Coordinate Generator

This block walks a raster scan of the output image and, for every visible pixel, produces the source coordinates at which a distorted input image should be sampled so that radial (barrel) lens distortion is undone. Positions are kept as signed offsets from the optical centre. The squares of both offsets are maintained with adders only, since each step changes a coordinate by one and the square then grows by twice the old value plus one.

The sum of the two squares is scaled by a signed distortion coefficient and clamped to the range of a magnification table. The upper bits of the scaled radius select two neighbouring table entries, and the lower bits weight a straight-line blend between them. The resulting magnification multiplies the centred x and y. The x and y values are held back three cycles so that each pixel meets its own magnification. One result leaves per clock after a fixed priming latency. Fetching and blending the source pixels is left to a downstream block.

Top module: `lens_undistort_gen`

## Requirements
- R1: After reset the output valid flag is 0. The first visible pixel uses x = -COLS/2 and y = -ROWS/2 (-16 and -12 with the default parameters).
- R2: A cycle with the visible flag high and the end-of-row flag low advances x by one and leaves y unchanged. A cycle with both flags low changes neither x nor y.
- R3: A cycle with the end-of-row flag high returns x to -COLS/2 and advances y by one. This holds even when the visible flag is also high; the pixel of that cycle is still produced from its position before the update.
- R4: The scaled radius is u = floor(((x*x + y*y) * k) / 2^RSH), with k signed. It is clamped to the range 0 to 2^(IW+FW)-1, so a zero or negative k gives u = 0.
- R5: The magnification table has 2^IW+1 entries. Entry i equals floor(2^MF * 2^IW / (2^IW + i)), so entry 0 is exactly 2^MF, which stands for unity.
- R6: The entry index is i = u / 2^FW and the weight is f = u mod 2^FW. The magnification is T[i] - floor((T[i] - T[i+1]) * f / 2^FW).
- R7: The corrected coordinates are floor(mag * x / 2^MF) and floor(mag * y / 2^MF), written as two's-complement values of CW bits.
- R8: The output valid flag equals the visible flag of exactly 4 cycles earlier, with one result per clock and no gaps added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vis_i | input | 1 | Current raster position is a visible pixel |
| row_end_i | input | 1 | End of the visible row; move to the next row |
| coef_k_i | input | K_W | Signed radial distortion coefficient |
| src_x_o | output | CW | Corrected source x, signed, centred |
| src_y_o | output | CW | Corrected source y, signed, centred |
| src_vld_o | output | 1 | Corrected coordinates are valid |

## Verification
The coefficient is set to zero so the output must reproduce the raw centred scan. This separates faults in the position counters and the delay alignment from faults in the table. Moderate fixed coefficients place the radius between table entries and exercise interpolation. Negative and maximal coefficients drive the clamp to both ends. A coefficient that changes on every pixel shows whether each magnification is paired with its own x and y. Rows with random gaps in the visible flag, and a row whose end flag coincides with its last pixel, separate stepping from holding and wrapping.

// File: rtl/lens_pkg.sv
package lens_pkg;

    // Default geometry and number formats
    localparam int DEF_CW   = 8;   // coordinate width (signed)
    localparam int DEF_COLS = 32;  // visible columns
    localparam int DEF_ROWS = 24;  // visible rows
    localparam int DEF_KW   = 8;   // coefficient width (signed)
    localparam int DEF_RSH  = 4;   // radius scale shift
    localparam int DEF_IW   = 5;   // table index bits
    localparam int DEF_FW   = 4;   // interpolation weight bits
    localparam int DEF_MF   = 10;  // magnification fraction bits

    // Raster tracker action for one cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_WRAP = 2'd2
    } track_act_e;

    // Magnification table entry: 2^mf * n / (n + i), n = 2^iw
    function automatic int mag_entry(input int i, input int iw, input int mf);
        longint n;
        longint num;
        n   = longint'(1) << iw;
        num = (longint'(1) << mf) * n;
        return int'(num / (n + longint'(i)));
    endfunction

    // Square of a small integer, used for reset constants
    function automatic int sq(input int v);
        return v * v;
    endfunction

endpackage

// File: rtl/lens_coord_tracker.sv
module lens_coord_tracker
    import lens_pkg::*;
#(
    parameter int CW   = DEF_CW,
    parameter int SQW  = 2 * DEF_CW,
    parameter int COLS = DEF_COLS,
    parameter int ROWS = DEF_ROWS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vis_i,
    input  logic                  eol_i,
    output logic signed [CW-1:0]  x_o,
    output logic signed [CW-1:0]  y_o,
    output logic [SQW-1:0]        sx_o,
    output logic [SQW-1:0]        sy_o
);

    localparam logic signed [CW-1:0] X0  = CW'(-(COLS / 2));
    localparam logic signed [CW-1:0] Y0  = CW'(-(ROWS / 2));
    localparam logic [SQW-1:0]       SX0 = SQW'(sq(COLS / 2));
    localparam logic [SQW-1:0]       SY0 = SQW'(sq(ROWS / 2));

    track_act_e act;
    logic signed [SQW-1:0] x_ext;
    logic signed [SQW-1:0] y_ext;
    logic [SQW-1:0]        sx_next;
    logic [SQW-1:0]        sy_next;

    always_comb begin
        if (eol_i)
            act = ACT_WRAP;
        else if (vis_i)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end

    // Running squares: (n+1)^2 = n^2 + 2n + 1
    assign x_ext   = {{(SQW-CW){x_o[CW-1]}}, x_o};
    assign y_ext   = {{(SQW-CW){y_o[CW-1]}}, y_o};
    assign sx_next = sx_o + SQW'(x_ext <<< 1) + SQW'(1);
    assign sy_next = sy_o + SQW'(y_ext <<< 1) + SQW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_o  <= X0;
            y_o  <= Y0;
            sx_o <= SX0;
            sy_o <= SY0;
        end else begin
            unique case (act)
                ACT_WRAP: begin
                    x_o  <= X0;
                    sx_o <= SX0;
                    y_o  <= y_o + CW'(1);
                    sy_o <= sy_next;
                end
                ACT_STEP: begin
                    x_o  <= x_o + CW'(1);
                    sx_o <= sx_next;
                end
                default: begin
                    x_o  <= x_o;
                    sx_o <= sx_o;
                end
            endcase
        end
    end

    // R2: visible pixel steps x only
    a_r2_x_step: assert property (@(posedge clk) disable iff (rst)
        (vis_i && !eol_i) |=> (x_o == $past(x_o) + CW'(1)) && (y_o == $past(y_o)));

    // R2: idle cycle holds the position
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!vis_i && !eol_i) |=> $stable(x_o) && $stable(y_o));

    // R3: end of row wraps x and advances y
    a_r3_row_wrap: assert property (@(posedge clk) disable iff (rst)
        eol_i |=> (x_o == X0) && (y_o == $past(y_o) + CW'(1)));

    // R4: incremental squares agree with direct squares
    a_r4_sq_track: assert property (@(posedge clk) disable iff (rst)
        (sx_o == SQW'(x_ext * x_ext)) && (sy_o == SQW'(y_ext * y_ext)));

endmodule

// File: rtl/lens_radius_scaler.sv
module lens_radius_scaler
    import lens_pkg::*;
#(
    parameter int SQW = 2 * DEF_CW,
    parameter int K_W = DEF_KW,
    parameter int RSH = DEF_RSH,
    parameter int IW  = DEF_IW,
    parameter int FW  = DEF_FW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SQW-1:0]        sx_i,
    input  logic [SQW-1:0]        sy_i,
    input  logic signed [K_W-1:0] k_i,
    output logic [IW+FW-1:0]      u_o
);

    localparam int UW = IW + FW;
    localparam int PW = SQW + 2 + K_W;
    localparam logic signed [PW-1:0] UMAX_S = PW'((2 ** UW) - 1);

    logic [SQW:0]          rsum;
    logic signed [PW-1:0]  rprod;
    logic signed [PW-1:0]  rshr;
    logic [UW-1:0]         u_next;

    assign rsum  = {1'b0, sx_i} + {1'b0, sy_i};
    assign rprod = $signed({1'b0, rsum}) * k_i;
    assign rshr  = rprod >>> RSH;

    always_comb begin
        if (rshr < 0)
            u_next = '0;
        else if (rshr > UMAX_S)
            u_next = UMAX_S[UW-1:0];
        else
            u_next = rshr[UW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            u_o <= '0;
        else
            u_o <= u_next;
    end

    // R4: non-positive coefficient leaves the radius at zero
    a_r4_nonpos_k: assert property (@(posedge clk) disable iff (rst)
        (k_i <= 0) |=> (u_o == '0));

    // R4: zero radius sum gives zero scaled radius
    a_r4_centre: assert property (@(posedge clk) disable iff (rst)
        (rsum == '0) |=> (u_o == '0));

endmodule

// File: rtl/lens_mag_table.sv
module lens_mag_table
    import lens_pkg::*;
#(
    parameter int IW = DEF_IW,
    parameter int FW = DEF_FW,
    parameter int MF = DEF_MF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IW+FW-1:0]  u_i,
    output logic [MF:0]       mag_o
);

    localparam int NT = 2 ** IW;
    localparam int DW = MF + FW + 1;

    logic [MF:0]   tab [NT+1];
    logic [IW-1:0] idx;
    logic [IW:0]   idx_nx;
    logic [FW-1:0] frac;

    logic [MF:0]   lo_q;
    logic [MF:0]   hi_q;
    logic [FW-1:0] f_q;
    logic [MF:0]   diff;
    logic [DW-1:0] dmul;
    logic [DW-1:0] corr;

    // Table computed from the reciprocal law at elaboration
    for (genvar g = 0; g <= NT; g++) begin : g_tab
        assign tab[g] = (MF+1)'(mag_entry(g, IW, MF));
    end

    assign idx    = u_i[IW+FW-1:FW];
    assign frac   = u_i[FW-1:0];
    assign idx_nx = {1'b0, idx} + (IW+1)'(1);

    // Cycle 1 of the lookup: read both neighbours
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
            f_q  <= '0;
        end else begin
            lo_q <= tab[idx];
            hi_q <= tab[idx_nx];
            f_q  <= frac;
        end
    end

    // Cycle 2 of the lookup: blend toward the next entry
    assign diff = lo_q - hi_q;
    assign dmul = DW'(diff) * DW'(f_q);
    assign corr = dmul >> FW;

    always_ff @(posedge clk) begin
        if (rst)
            mag_o <= '0;
        else
            mag_o <= lo_q - corr[MF:0];
    end

    // R5: neighbouring entries never increase
    a_r5_monotone: assert property (@(posedge clk) disable iff (rst)
        lo_q >= hi_q);

    // R6: blended value lies between its two entries
    a_r6_between: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mag_o <= $past(lo_q)) && (mag_o >= $past(hi_q)));

    // R6: zero weight returns the lower entry unchanged
    a_r6_exact: assert property (@(posedge clk) disable iff (rst)
        (f_q == '0) |=> (mag_o == $past(lo_q)));

endmodule

// File: rtl/lens_coord_scaler.sv
module lens_coord_scaler
    import lens_pkg::*;
#(
    parameter int CW   = DEF_CW,
    parameter int MF   = DEF_MF,
    parameter int XDLY = 3,
    parameter int LAT  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [CW-1:0]  x_i,
    input  logic signed [CW-1:0]  y_i,
    input  logic                  vis_i,
    input  logic [MF:0]           mag_i,
    output logic signed [CW-1:0]  cx_o,
    output logic signed [CW-1:0]  cy_o,
    output logic                  vld_o
);

    localparam int PW = MF + 2 + CW;

    logic signed [CW-1:0] xd [XDLY];
    logic signed [CW-1:0] yd [XDLY];
    logic [LAT-1:0]       vpipe;
    logic signed [PW-1:0] px;
    logic signed [PW-1:0] py;
    logic signed [PW-1:0] px_s;
    logic signed [PW-1:0] py_s;

    // Coordinate delay line, aligns x and y with their magnification
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < XDLY; i++) begin
                xd[i] <= '0;
                yd[i] <= '0;
            end
        end else begin
            xd[0] <= x_i;
            yd[0] <= y_i;
            for (int i = 1; i < XDLY; i++) begin
                xd[i] <= xd[i-1];
                yd[i] <= yd[i-1];
            end
        end
    end

    assign px   = $signed({1'b0, mag_i}) * xd[XDLY-1];
    assign py   = $signed({1'b0, mag_i}) * yd[XDLY-1];
    assign px_s = px >>> MF;
    assign py_s = py >>> MF;

    always_ff @(posedge clk) begin
        if (rst) begin
            cx_o  <= '0;
            cy_o  <= '0;
            vpipe <= '0;
        end else begin
            cx_o  <= px_s[CW-1:0];
            cy_o  <= py_s[CW-1:0];
            vpipe <= {vpipe[LAT-2:0], vis_i};
        end
    end

    assign vld_o = vpipe[LAT-1];

    // R7: a magnification of at most one never grows |x| and keeps the sign
    a_r7_x_neg: assert property (@(posedge clk) disable iff (rst)
        (xd[XDLY-1] < 0) |=> (cx_o >= $past(xd[XDLY-1])) && (cx_o <= 0));

    a_r7_x_pos: assert property (@(posedge clk) disable iff (rst)
        (xd[XDLY-1] >= 0) |=> (cx_o >= 0) && (cx_o <= $past(xd[XDLY-1])));

    // R7: unity magnification passes y through untouched
    a_r7_y_unity: assert property (@(posedge clk) disable iff (rst)
        (mag_i == (MF+1)'(2 ** MF)) |=> (cy_o == $past(yd[XDLY-1])));

endmodule

// File: rtl/lens_undistort_gen.sv
module lens_undistort_gen
    import lens_pkg::*;
#(
    parameter int CW   = DEF_CW,
    parameter int COLS = DEF_COLS,
    parameter int ROWS = DEF_ROWS,
    parameter int K_W  = DEF_KW,
    parameter int RSH  = DEF_RSH,
    parameter int IW   = DEF_IW,
    parameter int FW   = DEF_FW,
    parameter int MF   = DEF_MF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pix_vis_i,
    input  logic                  row_end_i,
    input  logic signed [K_W-1:0] coef_k_i,
    output logic signed [CW-1:0]  src_x_o,
    output logic signed [CW-1:0]  src_y_o,
    output logic                  src_vld_o
);

    localparam int SQW  = 2 * CW;
    localparam int XDLY = 3;
    localparam int LAT  = XDLY + 1;

    logic signed [CW-1:0] pos_x;
    logic signed [CW-1:0] pos_y;
    logic [SQW-1:0]       sq_x;
    logic [SQW-1:0]       sq_y;
    logic [IW+FW-1:0]     rad_u;
    logic [MF:0]          mag;

    lens_coord_tracker #(
        .CW(CW), .SQW(SQW), .COLS(COLS), .ROWS(ROWS)
    ) u_track (
        .clk(clk), .rst(rst),
        .vis_i(pix_vis_i), .eol_i(row_end_i),
        .x_o(pos_x), .y_o(pos_y), .sx_o(sq_x), .sy_o(sq_y)
    );

    lens_radius_scaler #(
        .SQW(SQW), .K_W(K_W), .RSH(RSH), .IW(IW), .FW(FW)
    ) u_rad (
        .clk(clk), .rst(rst),
        .sx_i(sq_x), .sy_i(sq_y), .k_i(coef_k_i), .u_o(rad_u)
    );

    lens_mag_table #(
        .IW(IW), .FW(FW), .MF(MF)
    ) u_mag (
        .clk(clk), .rst(rst), .u_i(rad_u), .mag_o(mag)
    );

    lens_coord_scaler #(
        .CW(CW), .MF(MF), .XDLY(XDLY), .LAT(LAT)
    ) u_scale (
        .clk(clk), .rst(rst),
        .x_i(pos_x), .y_i(pos_y), .vis_i(pix_vis_i), .mag_i(mag),
        .cx_o(src_x_o), .cy_o(src_y_o), .vld_o(src_vld_o)
    );

    // Cycles since reset, saturating, so the latency check never reads reset-time inputs
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 3'd7)
            since_rst <= since_rst + 3'd1;
    end

    // R8: valid follows the visible flag four cycles later
    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4) |-> (src_vld_o == $past(pix_vis_i, 4)));

    // R1: nothing valid in the first cycles after reset
    a_r1_quiet: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 3'd4) |-> !src_vld_o);

endmodule

// File: tb/tb_lens_undistort_gen.sv
module tb_lens_undistort_gen;

    localparam int CW = 8, COLS = 32, ROWS = 24, K_W = 8;
    localparam int RSH = 4, IW = 5, FW = 4, MF = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vis = 1'b0;
    logic eol = 1'b0;
    logic signed [K_W-1:0] kc = '0;
    logic signed [CW-1:0]  sx_o;
    logic signed [CW-1:0]  sy_o;
    logic                  vld_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Behavioural model state
    int mx, my;
    int qv[$], qx[$], qy[$];
    string qt[$];

    always #4 clk = ~clk; // 125 MHz

    lens_undistort_gen dut (
        .clk(clk), .rst(rst), .pix_vis_i(vis), .row_end_i(eol),
        .coef_k_i(kc), .src_x_o(sx_o), .src_y_o(sy_o), .src_vld_o(vld_o)
    );

    function automatic int tab(input int i);
        int n;
        n = 1 << IW;
        return ((1 << MF) * n) / (n + i);
    endfunction

    // Expected corrected value of coordinate c at position (x, y)
    function automatic int expect_c(input int x, input int y, input int k, input int c);
        int s, r, u, i, f, m, p;
        s = x * x + y * y;
        r = (s * k) >>> RSH;                    // R4
        if (r < 0) u = 0;
        else if (r > (1 << (IW + FW)) - 1) u = (1 << (IW + FW)) - 1;
        else u = r;
        i = u >> FW;                            // R6
        f = u & ((1 << FW) - 1);
        m = tab(i) - (((tab(i) - tab(i + 1)) * f) >> FW);   // R5
        p = (m * c) >>> MF;                     // R7
        return p;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: compare delayed expectation, then drive this cycle
    task automatic step(input bit v, input bit e, input int k, input string tag);
        int ev, ex, ey;
        string et;
        @(negedge clk);
        if (qv.size() == 4) begin
            ev = qv.pop_front(); ex = qx.pop_front();
            ey = qy.pop_front(); et = qt.pop_front();
            check(vld_o == ev[0], "R8", "valid", int'(vld_o), ev);
            if (ev != 0) begin
                check(int'(sx_o) == ex, et, "src_x", int'(sx_o), ex);
                check(int'(sy_o) == ey, et, "src_y", int'(sy_o), ey);
            end
        end else begin
            check(vld_o == 1'b0, "R1", "valid during priming", int'(vld_o), 0);
        end
        vis = v; eol = e; kc = K_W'(k);
        qv.push_back(int'(v));
        qx.push_back(v ? expect_c(mx, my, k, mx) : 0);
        qy.push_back(v ? expect_c(mx, my, k, my) : 0);
        qt.push_back(tag);
        if (e) begin
            mx = -(COLS / 2);
            my = my + 1;
        end else if (v) begin
            mx = mx + 1;
        end
    endtask

    // A full row of COLS visible pixels then an end-of-row cycle
    task automatic row(input int k, input string tag, input bit gaps, input bit rand_k);
        int n;
        int kk;
        n = 0;
        while (n < COLS) begin
            kk = rand_k ? (int'($urandom % 256) - 128) : k;
            if (gaps && ($urandom % 3 == 0)) begin
                step(1'b0, 1'b0, kk, tag);
            end else begin
                step(1'b1, 1'b0, kk, tag);
                n++;
            end
        end
        step(1'b0, 1'b1, k, tag);
    endtask

    initial begin
        mx = -(COLS / 2);
        my = -(ROWS / 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state shows through with unity magnification
        row(0, "R1", 1'b0, 1'b0);
        // R6: interpolated magnification, fixed coefficient
        for (int r = 0; r < 3; r++) row(20, "R6", 1'b0, 1'b0);
        // R2: gaps in the visible flag hold the position
        row(15, "R2", 1'b1, 1'b0);
        // R3: end of row together with the last visible pixel
        for (int c = 0; c < COLS - 1; c++) step(1'b1, 1'b0, 10, "R3");
        step(1'b1, 1'b1, 10, "R3");
        step(1'b1, 1'b0, 10, "R3");
        step(1'b0, 1'b0, 10, "R3");
        for (int c = 0; c < COLS - 1; c++) step(1'b1, 1'b0, 10, "R3");
        step(1'b0, 1'b1, 10, "R3");
        // R4: negative coefficient clamps to zero, maximal one saturates
        for (int r = 0; r < 2; r++) row(-50, "R4", 1'b0, 1'b0);
        for (int r = 0; r < 2; r++) row(127, "R4", 1'b0, 1'b0);
        // R5: coefficient changing every pixel sweeps the table
        for (int r = 0; r < 3; r++) row(0, "R5", 1'b0, 1'b1);
        // R7: continuous rows, back to back
        for (int r = 0; r < 2; r++) row(40, "R7", 1'b0, 1'b0);
        // Flush the pipeline
        repeat (6) step(1'b0, 1'b0, 0, "R8");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule